// File: doc/BRIEF.md
# BCD Calendar Real-Time Counter

This block keeps wall-clock time and date as packed BCD bytes. The bytes cover seconds, minutes, hours, day of month, month, a two-digit year standing for 2000–2099, and a weekday index. A one-cycle `ref_tick` strobe, taken from a 32768 Hz reference, drives a prescaler. After `PRESCALE` such strobes the calendar advances by one second. Rollovers follow each month's length and the every-fourth-year leap rule. Hours count in either 24-hour or 12-hour form.

Software reaches the block through a synchronous byte port with word-spaced addresses. It can read the calendar bytes at any time and load any one of them. It also sees a control byte, which holds the run enable and the hour format. A status byte reports a busy window before each update, mirrors the run state, holds sticky rollover events for second, minute, hour and day, and carries a power-up marker. An interrupt-enable byte lets the second event raise `sec_irq`.

The busy window is one reference period long and ends on the strobe that updates the time. Software that sees busy go low has most of a reference period in which no update can occur.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the time bytes read 0x00 (seconds, address 0x00), 0x00 (minutes, 0x04), 0x00 (hours, 0x08), 0x01 (day, 0x0C), 0x01 (month, 0x10), 0x00 (year, 0x14) and 0x00 (weekday, 0x18). Control (0x40) reads 0x00, interrupt enable (0x48) reads 0x00, and status (0x44) reads 0x80.
- R2: Status bit 7 is set only by reset. Writing status with bit 7 = 1 clears it.
- R3: While running, seconds advance once every `PRESCALE` reference strobes. A write to the seconds byte clears the prescaler, so the next advance comes exactly `PRESCALE` strobes later.
- R4: Status bit 0 (busy) is 1 from the strobe that leaves the prescaler one short of its limit until the strobe that updates the time, and 0 otherwise.
- R5: Seconds and minutes count BCD 00–59. 59 wraps to 00 and carries into the next field.
- R6: With control bit 3 = 0 (24-hour), hours count BCD 00–23, and 23 wrapping to 00 advances the day.
- R7: Control bit 0 = 1 lets time advance. With it at 0, strobes change nothing. Status bit 1 reads the run bit.
- R8: The day wraps to 01 after 28, 29, 30 or 31, following the month. February has 29 days when the binary year is divisible by 4, with 00 counting as a leap year.
- R9: Month counts BCD 01–12. 12 wraps to 01 and advances the year, which counts BCD 00–99 and wraps 99 to 00.
- R10: With control bit 3 = 1, the hours byte has PM in bit 7 and BCD 01–12 in bits 4:0. 11 goes to 12 with PM toggled, and 12 goes to 01 with PM kept. 11 PM going to 12 AM advances the day.
- R11: Status bits 2, 3, 4 and 5 are set on second, minute, hour and day rollover. They stay set until software writes 1 to that bit, and writing 0 leaves them unchanged.
- R12: `sec_irq` is high while interrupt-enable bit 2 is 1 and status bit 2 is set.
- R13: The weekday byte counts 0–6 and advances, 6 wrapping to 0, on every day rollover.
- R14: A write to any time byte is visible on the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe per 32768 Hz reference period |
| bus_wr | input | 1 | Write strobe for the byte port |
| bus_addr | input | 8 | Byte address, registers on 4-byte spacing |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| sec_irq | output | 1 | Second-event interrupt request |

## Verification
The bench targets month-end days, which a wrong month-length or leap decode would wrap too early or too late. It sweeps every month of five years, including 00, 24 and 99, starting from both the second-to-last and the last day.

It times the busy window strobe by strobe, so an off-by-one prescaler shows up as a late second or a busy bit that is high at the wrong time. The 12-hour checks cover 11→12 with the PM flip and 12→01 without it, where a naive BCD increment would reach 13. They also cover the 11 PM case that must advance the day. Further checks target event flags clearing the wrong bit, strobes leaking through while stopped, and a weekday stepping past 6.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

  localparam logic [7:0] A_SEC   = 8'h00;
  localparam logic [7:0] A_MIN   = 8'h04;
  localparam logic [7:0] A_HOUR  = 8'h08;
  localparam logic [7:0] A_DAY   = 8'h0C;
  localparam logic [7:0] A_MON   = 8'h10;
  localparam logic [7:0] A_YEAR  = 8'h14;
  localparam logic [7:0] A_WDAY  = 8'h18;
  localparam logic [7:0] A_CTRL  = 8'h40;
  localparam logic [7:0] A_STAT  = 8'h44;
  localparam logic [7:0] A_IEN   = 8'h48;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] day;
    logic [7:0] mon;
    logic [7:0] year;
    logic [7:0] wday;
  } rtc_time_t;

  // one-step increment of a two-digit BCD byte
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return v + 8'd1;
  endfunction

  // BCD year divisible by four: (10*t + u) mod 4 == (2*t + u) mod 4
  function automatic logic is_leap(input logic [7:0] y);
    logic [3:0] m;
    m = (y[4] ? 4'd2 : 4'd0) + y[3:0];
    return (m[1:0] == 2'd0);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] year);
    case (mon)
      8'h02:                      return is_leap(year) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/bcd_rtc_prescale.sv
module bcd_rtc_prescale #(
  parameter int PRESCALE = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic run_i,
  input  logic clr_i,
  output logic busy_o,
  output logic sec_stb_o
);
  localparam int CW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          stb;

  always_comb begin
    cnt_d = cnt_q;
    stb   = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
    end else if (tick_i && run_i) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        stb   = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    busy_d = (cnt_d == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o    = busy_q;
  assign sec_stb_o = stb;

  // R4: busy lasts no longer than one reference period while running
  a_r4_busy_one_period: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && tick_i && run_i && !clr_i) |=> !busy_q);

  // R4: an update only happens at the end of a busy window
  a_r4_update_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sec_stb_o |-> busy_q);

endmodule

// File: rtl/bcd_rtc_calendar.sv
module bcd_rtc_calendar
  import bcd_rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_stb_i,
  input  logic       mode12_i,
  input  logic       wr_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output rtc_time_t  time_o,
  output logic [3:0] ev_o,
  output logic       sec_wr_o
);
  rtc_time_t  t_q, t_d;
  logic [3:0] ev;
  logic       day_roll;
  logic [7:0] h12;

  always_comb begin
    t_d      = t_q;
    ev       = 4'b0;
    day_roll = 1'b0;
    h12      = {3'b0, t_q.hour[4:0]};
    if (sec_stb_i) begin
      ev[0] = 1'b1;
      if (t_q.sec == 8'h59) begin
        t_d.sec = 8'h00;
        ev[1]   = 1'b1;
        if (t_q.min == 8'h59) begin
          t_d.min = 8'h00;
          ev[2]   = 1'b1;
          if (mode12_i) begin
            if (h12 == 8'h11) begin
              t_d.hour = {~t_q.hour[7], 7'h12};
              day_roll = t_q.hour[7];
            end else if (h12 == 8'h12) begin
              t_d.hour = {t_q.hour[7], 7'h01};
            end else begin
              t_d.hour = {t_q.hour[7], 2'b0, bcd_inc(h12)[4:0]};
            end
          end else if (t_q.hour == 8'h23) begin
            t_d.hour = 8'h00;
            day_roll = 1'b1;
          end else begin
            t_d.hour = bcd_inc(t_q.hour);
          end
        end else begin
          t_d.min = bcd_inc(t_q.min);
        end
      end else begin
        t_d.sec = bcd_inc(t_q.sec);
      end
    end
    if (day_roll) begin
      ev[3]    = 1'b1;
      t_d.wday = (t_q.wday == 8'h06) ? 8'h00 : t_q.wday + 8'h01;
      if (t_q.day == last_day(t_q.mon, t_q.year)) begin
        t_d.day = 8'h01;
        if (t_q.mon == 8'h12) begin
          t_d.mon  = 8'h01;
          t_d.year = (t_q.year == 8'h99) ? 8'h00 : bcd_inc(t_q.year);
        end else begin
          t_d.mon = bcd_inc(t_q.mon);
        end
      end else begin
        t_d.day = bcd_inc(t_q.day);
      end
    end
    // a bus write to a field overrides any update of that field
    if (wr_i) begin
      case (addr_i)
        A_SEC:   t_d.sec  = wdata_i;
        A_MIN:   t_d.min  = wdata_i;
        A_HOUR:  t_d.hour = wdata_i;
        A_DAY:   t_d.day  = wdata_i;
        A_MON:   t_d.mon  = wdata_i;
        A_YEAR:  t_d.year = wdata_i;
        A_WDAY:  t_d.wday = wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, day: 8'h01,
               mon: 8'h01, year: 8'h00, wday: 8'h00};
    end else begin
      t_q <= t_d;
    end
  end

  assign time_o   = t_q;
  assign ev_o     = ev;
  assign sec_wr_o = wr_i && (addr_i == A_SEC);

  // R7: without an update strobe or a write, the calendar holds
  a_r7_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_stb_i && !wr_i) |=> $stable(t_q));

  // R5: seconds 59 wrap to 00 on an update
  a_r5_seconds_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_stb_i && !wr_i && t_q.sec == 8'h59) |=> (t_q.sec == 8'h00));

endmodule

// File: rtl/bcd_rtc_regs.sv
module bcd_rtc_regs
  import bcd_rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  input  rtc_time_t  time_i,
  input  logic       busy_i,
  input  logic [3:0] ev_i,
  output logic [7:0] rdata_o,
  output logic       run_o,
  output logic       mode12_o,
  output logic       irq_o
);
  logic       run_q, run_d, m12_q, m12_d, ien_q, ien_d, pwr_q, pwr_d;
  logic [3:0] ev_q, ev_d, ev_clr;
  logic       wr_ctrl, wr_stat, wr_ien;
  logic       unused_wbits;

  assign wr_ctrl = wr_i && (addr_i == A_CTRL);
  assign wr_stat = wr_i && (addr_i == A_STAT);
  assign wr_ien  = wr_i && (addr_i == A_IEN);
  assign unused_wbits = ^{wdata_i[6], wdata_i[1]};

  always_comb begin
    run_d  = wr_ctrl ? wdata_i[0] : run_q;
    m12_d  = wr_ctrl ? wdata_i[3] : m12_q;
    ien_d  = wr_ien  ? wdata_i[2] : ien_q;
    ev_clr = wr_stat ? wdata_i[5:2] : 4'b0;
    ev_d   = (ev_q & ~ev_clr) | ev_i;
    pwr_d  = pwr_q & ~(wr_stat & wdata_i[7]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      m12_q <= 1'b0;
      ien_q <= 1'b0;
      ev_q  <= 4'b0;
      pwr_q <= 1'b1;
    end else begin
      run_q <= run_d;
      m12_q <= m12_d;
      ien_q <= ien_d;
      ev_q  <= ev_d;
      pwr_q <= pwr_d;
    end
  end

  always_comb begin
    case (addr_i)
      A_SEC:   rdata_o = time_i.sec;
      A_MIN:   rdata_o = time_i.min;
      A_HOUR:  rdata_o = time_i.hour;
      A_DAY:   rdata_o = time_i.day;
      A_MON:   rdata_o = time_i.mon;
      A_YEAR:  rdata_o = time_i.year;
      A_WDAY:  rdata_o = time_i.wday;
      A_CTRL:  rdata_o = {4'b0, m12_q, 2'b0, run_q};
      A_STAT:  rdata_o = {pwr_q, 1'b0, ev_q, run_q, busy_i & run_q};
      A_IEN:   rdata_o = {5'b0, ien_q, 2'b0};
      default: rdata_o = 8'h00;
    endcase
  end

  assign run_o    = run_q;
  assign mode12_o = m12_q;
  assign irq_o    = ien_q & ev_q[0];

  // R2: the power-up marker never sets again after reset
  a_r2_powerup_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> !$rose(pwr_q));

  // R11: a minute event stays set until software clears it
  a_r11_minute_event_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q[1] && !(wr_stat && wdata_i[3])) |=> ev_q[1]);

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import bcd_rtc_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       bus_wr,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       sec_irq
);
  logic [1:0] rst_sync_q;
  logic       srst_n;
  logic       run, mode12, busy, sec_stb, sec_wr;
  logic [3:0] ev;
  rtc_time_t  cur_time;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  bcd_rtc_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst_n(srst_n), .tick_i(ref_tick), .run_i(run),
    .clr_i(sec_wr), .busy_o(busy), .sec_stb_o(sec_stb)
  );

  bcd_rtc_calendar u_cal (
    .clk(clk), .rst_n(srst_n), .sec_stb_i(sec_stb), .mode12_i(mode12),
    .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .time_o(cur_time), .ev_o(ev), .sec_wr_o(sec_wr)
  );

  bcd_rtc_regs u_regs (
    .clk(clk), .rst_n(srst_n), .wr_i(bus_wr), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .time_i(cur_time), .busy_i(busy), .ev_i(ev),
    .rdata_o(bus_rdata), .run_o(run), .mode12_o(mode12), .irq_o(sec_irq)
  );

endmodule

// File: tb/bcd_rtc_core_tb_top.sv
module bcd_rtc_core_tb_top;
  localparam int PS = 4;

  logic       clk, rst_n, ref_tick, bus_wr, sec_irq;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  bcd_rtc_core #(.PRESCALE(PS)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sec_irq(sec_irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
    end
  endtask

  function automatic logic [7:0] tobcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int mlen(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic set_time(input logic [7:0] yr, mo, dy, hr, mi, se);
    wr(8'h14, yr); wr(8'h10, mo); wr(8'h0C, dy);
    wr(8'h08, hr); wr(8'h04, mi); wr(8'h00, se);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int yrs [5] = '{0, 1, 23, 24, 99};
    rst_n = 1'b0; ref_tick = 1'b0; bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(8'h00, v); chk("R1 sec", v, 8'h00);
    rd(8'h04, v); chk("R1 min", v, 8'h00);
    rd(8'h08, v); chk("R1 hour", v, 8'h00);
    rd(8'h0C, v); chk("R1 day", v, 8'h01);
    rd(8'h10, v); chk("R1 month", v, 8'h01);
    rd(8'h14, v); chk("R1 year", v, 8'h00);
    rd(8'h18, v); chk("R1 weekday", v, 8'h00);
    rd(8'h40, v); chk("R1 ctrl", v, 8'h00);
    rd(8'h48, v); chk("R1 ien", v, 8'h00);
    rd(8'h44, v); chk("R1 status", v, 8'h80);

    // R7 stopped: strobes change nothing
    ticks(2 * PS);
    rd(8'h00, v); chk("R7 frozen while stopped", v, 8'h00);

    // R2 power-up flag clear, event-free write of 0 leaves it
    wr(8'h44, 8'h00);
    rd(8'h44, v); chk("R2 write 0 keeps flag", v, 8'h80);
    wr(8'h44, 8'h80);
    rd(8'h44, v); chk("R2 cleared by write 1", v, 8'h00);

    // R14 immediate load
    wr(8'h04, 8'h37);
    rd(8'h04, v); chk("R14 minutes load", v, 8'h37);

    // R3/R4 prescale and busy timing
    wr(8'h40, 8'h01);
    rd(8'h44, v); chk("R7 run mirrored", v, 8'h02);
    wr(8'h00, 8'h10);
    ticks(PS - 2);
    rd(8'h44, v); chk("R4 not busy early", v & 8'h01, 8'h00);
    ticks(1);
    rd(8'h44, v); chk("R4 busy before update", v & 8'h01, 8'h01);
    rd(8'h00, v); chk("R3 not yet advanced", v, 8'h10);
    ticks(1);
    rd(8'h44, v); chk("R4 busy falls at update", v & 8'h01, 8'h00);
    rd(8'h00, v); chk("R3 advanced after PRESCALE", v, 8'h11);
    ticks(PS - 1);
    wr(8'h00, 8'h20);
    ticks(PS - 1);
    rd(8'h00, v); chk("R3 write clears prescaler", v, 8'h20);
    ticks(1);
    rd(8'h00, v); chk("R3 advance after clear", v, 8'h21);

    // R12 interrupt
    rd(8'h44, v); chk("R11 second event set", v & 8'h04, 8'h04);
    chk("R12 irq masked", sec_irq, 1'b0);
    wr(8'h48, 8'h04);
    #1 chk("R12 irq with enable", sec_irq, 1'b1);
    wr(8'h44, 8'h04);
    #1 chk("R12 irq clears with flag", sec_irq, 1'b0);

    // R5 minute carry, R11 events
    wr(8'h44, 8'h3C);
    set_time(8'h00, 8'h01, 8'h01, 8'h05, 8'h17, 8'h59);
    ticks(PS);
    rd(8'h00, v); chk("R5 sec wrap", v, 8'h00);
    rd(8'h04, v); chk("R5 minute carry", v, 8'h18);
    rd(8'h44, v); chk("R11 sec+min events", v, 8'h0E);
    wr(8'h44, 8'h04);
    rd(8'h44, v); chk("R11 clears only written bit", v, 8'h0A);
    wr(8'h48, 8'h00);

    // R6 24h day rollover, R13 weekday, R11 all events
    wr(8'h44, 8'h3C);
    wr(8'h18, 8'h06);
    set_time(8'h00, 8'h01, 8'h05, 8'h23, 8'h59, 8'h59);
    ticks(PS);
    rd(8'h08, v); chk("R6 hour wraps", v, 8'h00);
    rd(8'h0C, v); chk("R6 day advances", v, 8'h06);
    rd(8'h18, v); chk("R13 weekday 6 to 0", v, 8'h00);
    rd(8'h44, v); chk("R11 all events", v, 8'h3E);
    set_time(8'h00, 8'h01, 8'h06, 8'h09, 8'h59, 8'h59);
    ticks(PS);
    rd(8'h08, v); chk("R6 hour increments", v, 8'h10);
    rd(8'h18, v); chk("R13 weekday held", v, 8'h00);

    // R8/R9 sweep of month ends
    foreach (yrs[yi]) begin
      for (int m = 1; m <= 12; m++) begin
        int len, ny, nm;
        len = mlen(m, yrs[yi]);
        set_time(tobcd(yrs[yi]), tobcd(m), tobcd(len - 1), 8'h23, 8'h59, 8'h59);
        ticks(PS);
        rd(8'h0C, v); chk("R8 day before end", v, tobcd(len));
        set_time(tobcd(yrs[yi]), tobcd(m), tobcd(len), 8'h23, 8'h59, 8'h59);
        ticks(PS);
        nm = (m == 12) ? 1 : m + 1;
        ny = (m == 12) ? (yrs[yi] + 1) % 100 : yrs[yi];
        rd(8'h0C, v); chk("R8 day wraps", v, 8'h01);
        rd(8'h10, v); chk("R9 month", v, tobcd(nm));
        rd(8'h14, v); chk("R9 year", v, tobcd(ny));
      end
    end

    // R10 12-hour mode
    wr(8'h40, 8'h09);
    rd(8'h40, v); chk("R10 ctrl readback", v, 8'h09);
    wr(8'h18, 8'h02);
    set_time(8'h00, 8'h01, 8'h05, 8'h11, 8'h59, 8'h59);
    ticks(PS);
    rd(8'h08, v); chk("R10 11AM to 12PM", v, 8'h92);
    rd(8'h0C, v); chk("R10 no day change at noon", v, 8'h05);
    set_time(8'h00, 8'h01, 8'h05, 8'h92, 8'h59, 8'h59);
    ticks(PS);
    rd(8'h08, v); chk("R10 12PM to 1PM", v, 8'h81);
    set_time(8'h00, 8'h01, 8'h05, 8'h09, 8'h59, 8'h59);
    ticks(PS);
    rd(8'h08, v); chk("R10 9AM to 10AM", v, 8'h10);
    set_time(8'h00, 8'h01, 8'h05, 8'h91, 8'h59, 8'h59);
    ticks(PS);
    rd(8'h08, v); chk("R10 11PM to 12AM", v, 8'h12);
    rd(8'h0C, v); chk("R10 day advances at midnight", v, 8'h06);
    rd(8'h18, v); chk("R13 weekday 2 to 3", v, 8'h03);

    // R7 stop again
    wr(8'h40, 8'h00);
    rd(8'h00, v);
    ticks(2 * PS);
    begin
      logic [7:0] v2;
      rd(8'h00, v2); chk("R7 frozen after clear", v2, v);
    end
    rd(8'h44, v); chk("R7 run bit low", v & 8'h03, 8'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule